// File: doc/BRIEF.md
# Per-Bank External Bus Sizer

This unit sits between a 32-bit internal access port and a narrow external data bus. Each of four external banks has its own bus width, 8 or 16 bits, held in a small width register. A byte, half-word or word request is broken into as many external sub-cycles as that width demands. Read bytes are gathered into one 32-bit result. Write bytes are steered onto the correct lanes of the 16-bit external bus.

A strap input fixes bank 0's width while reset is held, so a boot device of either width can be reached before software runs. Software may rewrite any bank's width afterwards through a one-cycle write strobe. Every external sub-cycle waits for the external ready handshake. The requester sees exactly one completion pulse, after the last sub-cycle. Requests that land in the reserved window, or in any undecoded region, finish with an error pulse and never start a bus cycle.

Top module: `ext_bus_sizer`

## Requirements
- R1: While `rst_n` is low at a clock edge, `cfg_width` loads `{3'b000, strap_wide}`. After reset `req_ready` is 1 and `done`, `err` and `ext_cs` are 0.
- R2: A cycle with `cfg_we` high loads `cfg_wdata` into `cfg_width` at that edge. Bit n set means bank n uses a 16-bit bus, and clear means an 8-bit bus.
- R3: A byte access takes one external sub-cycle. A half-word access to a 16-bit bank also takes one sub-cycle. `req_size` encodes 0 as byte, 1 as half-word and 2 as word.
- R4: A half-word access to an 8-bit bank takes two sub-cycles.
- R5: A word access to a 16-bit bank takes two sub-cycles.
- R6: A word access to an 8-bit bank takes four sub-cycles.
- R7: Sub-cycle k is driven at the request address plus k on an 8-bit bank, or plus 2k on a 16-bit bank. Lanes are little-endian. On an 8-bit bank, `ext_be` is 01, byte k goes on `ext_wdata[7:0]` and `ext_wdata[15:8]` is 0. On a 16-bit bank, a byte access drives `ext_be` 01 for an even address and 10 for an odd one, with the byte copied onto both lanes. Wider accesses drive `ext_be` 11 with half-word k.
- R8: Read data is assembled into `rdata` with the byte from the lowest address in bits 7:0, zero-extended above the access size. `rdata` is 0 on write and error completions.
- R9: A sub-cycle holds its address, lanes and data until `ext_ready` is sampled high. `done` pulses for one cycle, in the cycle after the last sub-cycle's handshake edge.
- R10: Addresses 0x00700000 to 0x007FFFFF are reserved. Addresses whose top byte is not 0x00, 0x02 or 0x03 are undecoded. A request to either kind of address raises `done` and `err` together in the cycle after acceptance, with no `ext_cs`.
- R11: Addresses 0x00800000 to 0x008FFFFF select bank 1. Top byte 0x02 selects bank 2 and top byte 0x03 selects bank 3. All other addresses with top byte 0x00 select bank 0.
- R12: A request takes the width its bank has before the edge that accepts it. A width-register write in that same cycle, or during the access, changes only later requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| strap_wide | input | 1 | Bank 0 width strap, sampled while reset is low |
| cfg_we | input | 1 | Width register write strobe |
| cfg_wdata | input | 4 | New per-bank width bits |
| cfg_width | output | 4 | Current per-bank width bits |
| req_valid | input | 1 | Internal request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | 0 byte, 1 half-word, 2 word |
| req_addr | input | 32 | Byte address, aligned to size |
| req_wdata | input | 32 | Write data, little-endian |
| req_ready | output | 1 | Unit idle, request taken this cycle |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Completion was a decode error |
| rdata | output | 32 | Assembled read data |
| ext_cs | output | 1 | External sub-cycle active |
| ext_we | output | 1 | External sub-cycle is a write |
| ext_addr | output | 32 | External byte address |
| ext_be | output | 2 | External lane enables |
| ext_wdata | output | 16 | External write data |
| ext_rdata | input | 16 | External read data |
| ext_ready | input | 1 | External sub-cycle may complete |

## Verification
Two events can meet in one cycle: a write to the width register and the acceptance of a request for the bank whose bit it flips. The bench drives both on the same edge and checks that the running access keeps the old width, judged by sub-cycle count and address stride, and that the next access uses the new width. It also flips a bank's bit while a stalled four-cycle split is in progress and checks that the split still completes as 8-bit. All other traffic is a sweep over every bank, both widths, all sizes, all aligned offsets and both directions, with varying wait states. The expected beats and the read data come from a byte pattern the bench computes from the address.

// File: rtl/ext_bus_sizer.sv
`timescale 1ns/1ps
module ext_bus_sizer #(
  parameter logic [11:0] RSV_SEG = 12'h007,
  parameter logic [11:0] DEV_SEG = 12'h008,
  parameter logic [7:0]  LOW_TOP = 8'h00,
  parameter logic [7:0]  DRA_TOP = 8'h02,
  parameter logic [7:0]  DRB_TOP = 8'h03
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        strap_wide,
  input  logic        cfg_we,
  input  logic [3:0]  cfg_wdata,
  output logic [3:0]  cfg_width,
  input  logic        req_valid,
  input  logic        req_write,
  input  logic [1:0]  req_size,
  input  logic [31:0] req_addr,
  input  logic [31:0] req_wdata,
  output logic        req_ready,
  output logic        done,
  output logic        err,
  output logic [31:0] rdata,
  output logic        ext_cs,
  output logic        ext_we,
  output logic [31:0] ext_addr,
  output logic [1:0]  ext_be,
  output logic [15:0] ext_wdata,
  input  logic [15:0] ext_rdata,
  input  logic        ext_ready
);

  logic [3:0]  width_q;
  logic        busy_q, wide_q, wr_q, done_q, err_q;
  logic [1:0]  size_q, idx_q, last_q;
  logic [31:0] base_q, wbuf_q, rbuf_q;

  logic [1:0]  bank;
  logic        bad;
  logic [1:0]  be;
  logic [15:0] wd;
  logic [31:0] rd_merge, wshift, hshift;
  logic [2:0]  off;

  function automatic logic [1:0] last_index(input logic wide, input logic [1:0] size);
    case (size)
      2'd0:    return 2'd0;
      2'd1:    return wide ? 2'd0 : 2'd1;
      default: return wide ? 2'd1 : 2'd3;
    endcase
  endfunction

  always_comb begin
    bad  = 1'b0;
    bank = 2'd0;
    if (req_addr[31:20] == RSV_SEG)      bad  = 1'b1;
    else if (req_addr[31:20] == DEV_SEG) bank = 2'd1;
    else if (req_addr[31:24] == LOW_TOP) bank = 2'd0;
    else if (req_addr[31:24] == DRA_TOP) bank = 2'd2;
    else if (req_addr[31:24] == DRB_TOP) bank = 2'd3;
    else                                 bad  = 1'b1;
  end

  wire accept   = req_valid && !busy_q;
  wire hs       = busy_q && ext_ready;
  wire is_last  = (idx_q == last_q);
  wire sel_wide = width_q[bank];

  always_ff @(posedge clk) begin
    if (!rst_n)      width_q <= {3'b000, strap_wide};
    else if (cfg_we) width_q <= cfg_wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0; wide_q <= 1'b0; wr_q <= 1'b0;
      done_q <= 1'b0; err_q  <= 1'b0;
      size_q <= 2'd0; idx_q  <= 2'd0; last_q <= 2'd0;
      base_q <= '0;   wbuf_q <= '0;   rbuf_q <= '0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      if (accept) begin
        rbuf_q <= '0;
        if (bad) begin
          done_q <= 1'b1;
          err_q  <= 1'b1;
        end else begin
          busy_q <= 1'b1;
          wide_q <= sel_wide;
          wr_q   <= req_write;
          size_q <= req_size;
          idx_q  <= 2'd0;
          last_q <= last_index(sel_wide, req_size);
          base_q <= req_addr;
          wbuf_q <= req_wdata;
        end
      end else if (hs) begin
        if (!wr_q) rbuf_q <= rbuf_q | rd_merge;
        if (is_last) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end else begin
          idx_q <= idx_q + 2'd1;
        end
      end
    end
  end

  always_comb begin
    wshift = wbuf_q >> {idx_q, 3'b000};
    hshift = wbuf_q >> {idx_q, 4'b0000};
    off    = wide_q ? {idx_q, 1'b0} : {1'b0, idx_q};
    if (!wide_q) begin
      be       = 2'b01;
      wd       = {8'h00, wshift[7:0]};
      rd_merge = {24'h0, ext_rdata[7:0]} << {idx_q, 3'b000};
    end else if (size_q == 2'd0) begin
      be       = base_q[0] ? 2'b10 : 2'b01;
      wd       = {2{wbuf_q[7:0]}};
      rd_merge = {24'h0, base_q[0] ? ext_rdata[15:8] : ext_rdata[7:0]};
    end else begin
      be       = 2'b11;
      wd       = hshift[15:0];
      rd_merge = {16'h0, ext_rdata} << {idx_q, 4'b0000};
    end
  end

  assign ext_cs    = busy_q;
  assign ext_we    = busy_q & wr_q;
  assign ext_addr  = base_q + {29'd0, off};
  assign ext_be    = busy_q ? be : 2'b00;
  assign ext_wdata = wd;
  assign req_ready = !busy_q;
  assign done      = done_q;
  assign err       = err_q;
  assign rdata     = rbuf_q;
  assign cfg_width = width_q;

  AST_CFG_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> (cfg_width == $past(cfg_wdata))); // R2
  AST_SUB_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    ext_cs |-> (idx_q <= last_q)); // R6
  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (hs && !is_last) |=> (ext_addr == $past(ext_addr) + (wide_q ? 32'd2 : 32'd1))); // R7
  AST_NARROW_LANE: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_cs && !wide_q) |-> (ext_be == 2'b01 && ext_wdata[15:8] == 8'h00)); // R7
  AST_HOLD_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_cs && !ext_ready) |=> (ext_cs && $stable(ext_addr) && $stable(ext_wdata) && $stable(ext_be))); // R9
  AST_LAST_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (hs && is_last) |=> (done && !ext_cs)); // R9
  AST_ERR_NO_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (done && !ext_cs)); // R10
  AST_WIDTH_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_cs && !(ext_ready && is_last)) |=> $stable(wide_q)); // R12

endmodule

// File: tb/test_ext_bus_sizer.sv
`timescale 1ns/1ps
module test_ext_bus_sizer;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst_n = 1'b0, strap_wide = 1'b1;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_wdata = 4'h0;
  logic [3:0]  cfg_width;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [1:0]  req_size = 2'd0;
  logic [31:0] req_addr = '0, req_wdata = '0;
  logic        req_ready, done, err;
  logic [31:0] rdata;
  logic        ext_cs, ext_we;
  logic [31:0] ext_addr;
  logic [1:0]  ext_be;
  logic [15:0] ext_wdata, ext_rdata;
  logic        ext_ready = 1'b0;

  ext_bus_sizer i_ext_bus_sizer (.*);

  int checks = 0, errors = 0;
  logic [3:0] shadow = 4'h1;
  int waits = 0;
  logic bus_wide = 1'b0;
  logic [31:0] b_addr [8];
  logic [1:0]  b_be   [8];
  logic [15:0] b_wd   [8];
  logic        b_we   [8];
  int nb = 0;

  function automatic logic [7:0] mb(input logic [31:0] a);
    return a[7:0] * 8'd13 + a[15:8] + 8'h5A;
  endfunction

  assign ext_rdata = bus_wide ? {mb(ext_addr | 32'd1), mb(ext_addr & ~32'd1)}
                              : {~mb(ext_addr), mb(ext_addr)};

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  initial begin
    int wc = 0;
    forever begin
      @(negedge clk);
      if (ext_cs && wc >= waits) begin
        ext_ready = 1'b1;
        if (nb < 8) begin
          b_addr[nb] = ext_addr; b_be[nb] = ext_be;
          b_wd[nb] = ext_wdata;  b_we[nb] = ext_we;
        end
        nb++;
        wc = 0;
      end else begin
        ext_ready = 1'b0;
        if (ext_cs) wc++;
      end
    end
  end

  task automatic decode(input logic [31:0] a, output bit bad, output int bank);
    bad = 0; bank = 0;
    if (a[31:20] == 12'h007) bad = 1;
    else if (a[31:20] == 12'h008) bank = 1;
    else if (a[31:24] == 8'h00) bank = 0;
    else if (a[31:24] == 8'h02) bank = 2;
    else if (a[31:24] == 8'h03) bank = 3;
    else bad = 1;
  endtask

  task automatic do_reset(input logic s);
    rst_n = 1'b0; strap_wide = s;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    shadow = {3'b000, s};
    chk(cfg_width == {3'b000, s}, "R1 strap width", {28'h0, cfg_width}, {31'h0, s});
    chk(req_ready && !done && !err && !ext_cs, "R1 idle outputs",
        {28'h0, req_ready, done, err, ext_cs}, 32'h8);
  endtask

  task automatic cfg_set(input logic [3:0] v);
    @(negedge clk);
    cfg_we = 1'b1; cfg_wdata = v;
    @(negedge clk);
    cfg_we = 1'b0;
    shadow = v;
    chk(cfg_width == v, "R2 width write", {28'h0, cfg_width}, {28'h0, v});
  endtask

  task automatic do_access(input bit wr, input logic [1:0] sz, input logic [31:0] a,
                           input logic [31:0] wd, input bit cfg_also, input logic [3:0] cfg_new,
                           input string tag);
    bit bad; int bank; bit wide; int n; int cyc; int ecyc;
    logic [31:0] erd;
    decode(a, bad, bank);
    wide = bad ? 1'b0 : shadow[bank];
    bus_wide = wide;
    n = bad ? 0 : (sz == 0 ? 1 : (sz == 1 ? (wide ? 1 : 2) : (wide ? 2 : 4)));
    ecyc = bad ? 1 : 1 + n * (waits + 1);
    erd = '0;
    if (!bad && !wr)
      for (int i = 0; i < (1 << sz); i++) erd = erd | ({24'h0, mb(a + i)} << (8 * i));
    @(negedge clk);
    nb = 0;
    req_valid = 1'b1; req_write = wr; req_size = sz; req_addr = a; req_wdata = wd;
    if (cfg_also) begin cfg_we = 1'b1; cfg_wdata = cfg_new; end
    @(negedge clk);
    req_valid = 1'b0;
    if (cfg_also) begin cfg_we = 1'b0; shadow = cfg_new; end
    cyc = 1;
    while (!done && cyc < 200) begin @(negedge clk); cyc++; end
    chk(done == 1'b1, {tag, " R9 done seen"}, {31'h0, done}, 32'h1);
    chk(cyc == ecyc, {tag, " R9 latency"}, cyc, ecyc);
    chk(err == bad, {tag, " R10 err flag"}, {31'h0, err}, {31'h0, bad});
    chk(nb == n, {tag, " R3 R4 R5 R6 sub-cycle count"}, nb, n);
    chk(rdata == erd, {tag, " R8 read data"}, rdata, erd);
    for (int k = 0; k < n && k < nb; k++) begin
      logic [31:0] ea; logic [1:0] ebe; logic [15:0] ewd;
      ea = a + (wide ? 2 * k : k);
      if (!wide) begin ebe = 2'b01; ewd = {8'h00, wd[8*k +: 8]}; end
      else if (sz == 0) begin ebe = a[0] ? 2'b10 : 2'b01; ewd = {2{wd[7:0]}}; end
      else begin ebe = 2'b11; ewd = wd[16*k +: 16]; end
      chk(b_addr[k] == ea, {tag, " R7 beat address"}, b_addr[k], ea);
      chk(b_be[k] == ebe, {tag, " R7 beat lanes"}, {30'h0, b_be[k]}, {30'h0, ebe});
      chk(b_we[k] == wr, {tag, " R7 beat direction"}, {31'h0, b_we[k]}, {31'h0, wr});
      if (wr) chk(b_wd[k] == ewd, {tag, " R7 beat data"}, {16'h0, b_wd[k]}, {16'h0, ewd});
    end
    @(negedge clk);
    chk(done == 1'b0, {tag, " R9 single pulse"}, {31'h0, done}, 32'h0);
  endtask

  task automatic summary;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(4 * 150000);
    checks++; errors++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    logic [31:0] base [4];
    base[0] = 32'h0000_1000; base[1] = 32'h0080_0010;
    base[2] = 32'h0200_0020; base[3] = 32'h0300_0040;

    do_reset(1'b1);
    waits = 0;
    do_access(0, 2'd2, 32'h0000_0100, '0, 0, 4'h0, "R1 strap-high bank0");

    for (int b = 0; b < 4; b++)
      for (int w = 0; w < 2; w++) begin
        cfg_set(w ? (4'b0001 << b) : ~(4'b0001 << b));
        for (int sz = 0; sz < 3; sz++)
          for (int off = 0; off < 4; off += (1 << sz))
            for (int wr = 0; wr < 2; wr++) begin
              waits = (off + sz + wr) % 3;
              do_access(wr[0], sz[1:0], base[b] + off,
                        32'hA1B2_C3D4 ^ (off * 32'h0101_0101) ^ b, 0, 4'h0, "R11 sweep");
            end
      end

    waits = 1;
    cfg_set(4'b0010);
    do_access(0, 2'd2, 32'h006F_FFFC, '0, 0, 4'h0, "R11 below reserved");
    do_access(0, 2'd2, 32'h0080_0000, '0, 0, 4'h0, "R11 device low");
    do_access(1, 2'd2, 32'h008F_FFFC, 32'h1234_5678, 0, 4'h0, "R11 device high");
    do_access(0, 2'd2, 32'h0090_0000, '0, 0, 4'h0, "R11 above device");
    do_access(0, 2'd2, 32'h0070_0000, '0, 0, 4'h0, "R10 reserved low");
    do_access(1, 2'd0, 32'h007F_FFFF, 32'hFF, 0, 4'h0, "R10 reserved high");
    do_access(0, 2'd1, 32'h0100_0000, '0, 0, 4'h0, "R10 undecoded 01");
    do_access(0, 2'd2, 32'hFF00_0000, '0, 0, 4'h0, "R10 undecoded FF");

    waits = 0;
    cfg_set(4'b0000);
    do_access(0, 2'd2, 32'h0300_0100, '0, 1, 4'b1000, "R12 same-cycle write");
    chk(cfg_width == 4'b1000, "R12 write landed", {28'h0, cfg_width}, 32'h8);
    do_access(0, 2'd2, 32'h0300_0100, '0, 0, 4'h0, "R12 new width used");

    waits = 3;
    cfg_set(4'b0000);
    fork
      do_access(1, 2'd2, 32'h0200_0200, 32'hCAFE_F00D, 0, 4'h0, "R12 mid-access write");
      begin repeat (4) @(negedge clk); cfg_set(4'b0100); end
    join
    waits = 0;
    do_access(1, 2'd2, 32'h0200_0200, 32'hCAFE_F00D, 0, 4'h0, "R12 after mid write");

    do_reset(1'b0);
    do_access(0, 2'd2, 32'h0000_0100, '0, 0, 4'h0, "R1 strap-low bank0");
    summary();
  end
endmodule